// File: doc/BRIEF.md
# Rendezvous Channel Controller

This block is a set of unbuffered, one-way message channels between processes, with small process identifiers. Each channel pairs one sending process with one receiving process. Its whole state is one word. That word either holds a marker meaning "nobody waiting" or records the parked process: its identifier, its priority and which side it took. The first process to arrive is parked and reported as descheduled. When the opposite side arrives, the data word moves in a single transfer, the parked process is released to the scheduler and the channel returns to empty.

A separate event channel carries no data. An external interrupt pin drives it. The pin is synchronised and its rising edge is detected. The edge releases a process waiting for input on the event channel. If nobody is waiting, the edge is held until a process inputs on the event channel, and that input then completes at once. A high-priority process released by the event is flagged for immediate execution. A low-priority one is flagged to join the back of its ready queue.

Requests enter on a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold its fields stable until that edge. `req_ready` drops for exactly the one cycle in which an event release fires, so that only one release is reported per cycle. The result pulses have no back-pressure: the scheduler must take each of them in the cycle it appears. Every result appears one clock after the request is taken.

Top module: `rdv_channel_ctrl`

## Requirements
- R1: After reset `req_ready` is high, all result pulses are low and every channel and the event channel are empty, so the first request on any of them parks.
- R2: A request (`req_op` 2'b01 = output, 2'b10 = input) on an empty channel gives `park_valid` with `park_pid` equal to the requester, one cycle after acceptance. At most one of park, done and error is reported per request.
- R3: An input on a channel where a sender is parked, or an output on a channel where a receiver is parked, completes in one step. It gives `done_valid` for the requester, `rx_valid` with the receiver's id and the sender's data, and `wake_valid` with the parked process's id and priority and `wake_now` low. The channel is then empty again.
- R4: A request of the same direction as the process already parked is reported with `err_valid` only. The channel keeps its parked process and its data.
- R5: A channel request with `req_ch` not below `NUM_CH` is reported with `err_valid` and changes no channel.
- R6: Channels are independent; traffic on one does not disturb a process parked on another.
- R7: A rising edge on `irq` while a process waits on the event channel (`req_op` 2'b11) releases it through `wake_valid` three clocks after the pin rises. `wake_now` equals the process's priority (1 = high, run at once; 0 = back of queue).
- R8: A rising edge with no waiter is latched. The next event input then gets `done_valid` instead of parking, and the latch is cleared, so a following event input parks.
- R9: An event input while a process already waits on the event channel is reported with `err_valid` and leaves the waiter in place.
- R10: `req_ready` is low during the cycle in which an event release fires. A request presented then is taken on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 2 | 01 output, 10 input, 11 event input, 00 none |
| req_ch | input | CH_W | Channel index |
| req_pid | input | PID_W | Requesting process id |
| req_pri | input | 1 | Requester priority, 1 = high |
| req_data | input | DATA_W | Data word for an output |
| irq | input | 1 | Asynchronous interrupt pin |
| park_valid | output | 1 | Requester descheduled |
| park_pid | output | PID_W | Parked process id |
| done_valid | output | 1 | Requester completed without parking |
| done_pid | output | PID_W | Completed requester id |
| rx_valid | output | 1 | Data delivered to a receiver |
| rx_pid | output | PID_W | Receiving process id |
| rx_data | output | DATA_W | Delivered data |
| wake_valid | output | 1 | Parked process released |
| wake_pid | output | PID_W | Released process id |
| wake_pri | output | 1 | Released process priority |
| wake_now | output | 1 | Release is for immediate execution |
| err_valid | output | 1 | Protocol error, no state change |

## Verification
The bench builds the block with three channels, 32-bit words and 6-bit process ids. With a channel count that is not a power of two, index 3 can be driven on the two-bit channel port, and the out-of-range error path can be exercised. Directed tasks cover:
- both arrival orders on a channel;
- same-direction collisions;
- independent channels;
- event releases at each priority;
- a latched early event;
- a request held across the stall cycle of an event release.

// File: rtl/rdv_pkg.sv
package rdv_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_OUT  = 2'b01,
    OP_IN   = 2'b10,
    OP_EVIN = 2'b11
  } rdv_op_e;
endpackage

// File: rtl/rdv_irq_sync.sv
module rdv_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq,
  output logic rise_o
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], irq};
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/rdv_chan_slot.sv
module rdv_chan_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              wr_data_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] word_o,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [DATA_W-1:0] EMPTY = {1'b1, {(DATA_W-1){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o <= EMPTY;
      data_o <= '0;
    end else if (wr_en) begin
      word_o <= wr_word;
      if (wr_data_en) data_o <= wr_data;
    end
  end

  // R1: the sign bit only ever appears as the exact empty marker
  p_marker_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
    word_o[DATA_W-1] |-> (word_o == EMPTY));
endmodule

// File: rtl/rdv_event_chan.sv
module rdv_event_chan #(
  parameter int DATA_W = 32,
  parameter int PID_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             req_i,
  input  logic [PID_W-1:0] pid_i,
  input  logic             pri_i,
  output logic             fire_o,
  output logic [PID_W-1:0] fire_pid_o,
  output logic             fire_pri_o,
  output logic             park_o,
  output logic             done_o,
  output logic             err_o
);
  localparam logic [DATA_W-1:0] EMPTY = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] ev_word;
  logic              pending;
  logic              waiting;
  logic              avail;

  assign waiting    = (ev_word != EMPTY);
  assign avail      = pending | rise_i;
  assign fire_o     = rise_i & waiting;
  assign fire_pid_o = ev_word[PID_W-1:0];
  assign fire_pri_o = ev_word[PID_W];
  assign err_o      = req_i & waiting;
  assign done_o     = req_i & ~waiting & avail;
  assign park_o     = req_i & ~waiting & ~avail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_word <= EMPTY;
      pending <= 1'b0;
    end else begin
      if (fire_o) begin
        ev_word <= EMPTY;
      end else if (park_o) begin
        ev_word           <= '0;
        ev_word[PID_W-1:0] <= pid_i;
        ev_word[PID_W]    <= pri_i;
      end
      if (done_o)                  pending <= 1'b0;
      else if (rise_i && !waiting) pending <= 1'b1;
    end
  end

  // R8: a latched event and a parked waiter never coexist
  p_latch_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !waiting);
endmodule

// File: rtl/rdv_channel_ctrl.sv
module rdv_channel_ctrl
  import rdv_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PID_W    = 6,
  parameter int NUM_CH   = 4,
  parameter int SYNC_STG = 2,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [CH_W-1:0]   req_ch,
  input  logic [PID_W-1:0]  req_pid,
  input  logic              req_pri,
  input  logic [DATA_W-1:0] req_data,
  input  logic              irq,
  output logic              park_valid,
  output logic [PID_W-1:0]  park_pid,
  output logic              done_valid,
  output logic [PID_W-1:0]  done_pid,
  output logic              rx_valid,
  output logic [PID_W-1:0]  rx_pid,
  output logic [DATA_W-1:0] rx_data,
  output logic              wake_valid,
  output logic [PID_W-1:0]  wake_pid,
  output logic              wake_pri,
  output logic              wake_now,
  output logic              err_valid
);
  localparam logic [DATA_W-1:0] EMPTY = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [CH_W:0]     NCH   = NUM_CH[CH_W:0];
  localparam int                DIR_B = PID_W + 1;

  rdv_op_e           op;
  logic              acc;
  logic              ch_ok;
  logic [CH_W-1:0]   ch_idx;
  logic              is_out;
  logic [DATA_W-1:0] words [NUM_CH];
  logic [DATA_W-1:0] datas [NUM_CH];
  logic [DATA_W-1:0] sel_word, sel_data;
  logic [NUM_CH-1:0] wr_en;
  logic [DATA_W-1:0] wr_word;
  logic              wr_data_en;

  logic              rise, ev_req, ev_fire, ev_pri, ev_park, ev_done, ev_err;
  logic [PID_W-1:0]  ev_pid;

  logic              n_park, n_done, n_rx, n_wake, n_wpri, n_wnow, n_err;
  logic [PID_W-1:0]  n_rxpid, n_wpid;
  logic [DATA_W-1:0] n_rxdata;

  assign op        = rdv_op_e'(req_op);
  assign req_ready = ~ev_fire;
  assign acc       = req_valid & req_ready;
  assign ch_ok     = ({1'b0, req_ch} < NCH);
  assign ch_idx    = ch_ok ? req_ch : '0;
  assign is_out    = (op == OP_OUT);
  assign sel_word  = words[ch_idx];
  assign sel_data  = datas[ch_idx];
  assign ev_req    = acc & (op == OP_EVIN);

  rdv_irq_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .irq(irq), .rise_o(rise));

  rdv_event_chan #(.DATA_W(DATA_W), .PID_W(PID_W)) u_event (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .req_i(ev_req),
    .pid_i(req_pid), .pri_i(req_pri), .fire_o(ev_fire),
    .fire_pid_o(ev_pid), .fire_pri_o(ev_pri), .park_o(ev_park),
    .done_o(ev_done), .err_o(ev_err));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    rdv_chan_slot #(.DATA_W(DATA_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en[g]), .wr_word(wr_word),
      .wr_data_en(wr_data_en), .wr_data(req_data),
      .word_o(words[g]), .data_o(datas[g]));
  end

  always_comb begin
    n_park = 1'b0; n_done = 1'b0; n_rx = 1'b0; n_wake = 1'b0;
    n_wpri = 1'b0; n_wnow = 1'b0; n_err = 1'b0;
    n_rxpid = '0; n_wpid = '0; n_rxdata = '0;
    wr_en = '0; wr_word = EMPTY; wr_data_en = 1'b0;
    if (acc) begin
      unique case (op)
        OP_OUT, OP_IN: begin
          if (!ch_ok) begin
            n_err = 1'b1;
          end else if (sel_word == EMPTY) begin
            n_park              = 1'b1;
            wr_en[ch_idx]       = 1'b1;
            wr_word             = '0;
            wr_word[PID_W-1:0]  = req_pid;
            wr_word[PID_W]      = req_pri;
            wr_word[DIR_B]      = is_out;
            wr_data_en          = is_out;
          end else if (sel_word[DIR_B] == is_out) begin
            n_err = 1'b1;
          end else begin
            n_done        = 1'b1;
            n_rx          = 1'b1;
            n_wake        = 1'b1;
            n_wpid        = sel_word[PID_W-1:0];
            n_wpri        = sel_word[PID_W];
            wr_en[ch_idx] = 1'b1;
            if (is_out) begin
              n_rxpid  = sel_word[PID_W-1:0];
              n_rxdata = req_data;
            end else begin
              n_rxpid  = req_pid;
              n_rxdata = sel_data;
            end
          end
        end
        OP_EVIN: begin
          n_park = ev_park;
          n_done = ev_done;
          n_err  = ev_err;
        end
        default: ;
      endcase
    end
    if (ev_fire) begin
      n_wake = 1'b1;
      n_wpid = ev_pid;
      n_wpri = ev_pri;
      n_wnow = ev_pri;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      park_valid <= 1'b0; park_pid <= '0;
      done_valid <= 1'b0; done_pid <= '0;
      rx_valid   <= 1'b0; rx_pid   <= '0; rx_data <= '0;
      wake_valid <= 1'b0; wake_pid <= '0; wake_pri <= 1'b0; wake_now <= 1'b0;
      err_valid  <= 1'b0;
    end else begin
      park_valid <= n_park; park_pid <= req_pid;
      done_valid <= n_done; done_pid <= req_pid;
      rx_valid   <= n_rx;   rx_pid   <= n_rxpid; rx_data <= n_rxdata;
      wake_valid <= n_wake; wake_pid <= n_wpid;
      wake_pri   <= n_wpri; wake_now <= n_wnow;
      err_valid  <= n_err;
    end
  end

  // R2: one outcome at most per accepted request
  p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({park_valid, done_valid, err_valid}));
  // R3: a transfer always completes the requester and releases the partner
  p_xfer_pairs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (done_valid && wake_valid && !wake_now));
  // R4: an error never moves data
  p_err_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> !rx_valid);
  // R7: immediate execution only for a high-priority release
  p_now_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_now |-> (wake_valid && wake_pri));
  // R10: a stall cycle is always followed by a release pulse
  p_stall_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> wake_valid);
endmodule

// File: tb/test_rdv_channel_ctrl.sv
module test_rdv_channel_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int PW = 6;
  localparam int NC = 3;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'b00;
  logic [CW-1:0] req_ch = '0;
  logic [PW-1:0] req_pid = '0;
  logic          req_pri = 1'b0;
  logic [DW-1:0] req_data = '0;
  logic          irq = 1'b0;
  logic          park_valid, done_valid, rx_valid, wake_valid, wake_pri, wake_now, err_valid;
  logic [PW-1:0] park_pid, done_pid, rx_pid, wake_pid;
  logic [DW-1:0] rx_data;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdv_channel_ctrl #(.DATA_W(DW), .PID_W(PW), .NUM_CH(NC)) i_rdv_channel_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_ch(req_ch), .req_pid(req_pid), .req_pri(req_pri),
    .req_data(req_data), .irq(irq),
    .park_valid(park_valid), .park_pid(park_pid),
    .done_valid(done_valid), .done_pid(done_pid),
    .rx_valid(rx_valid), .rx_pid(rx_pid), .rx_data(rx_data),
    .wake_valid(wake_valid), .wake_pid(wake_pid), .wake_pri(wake_pri),
    .wake_now(wake_now), .err_valid(err_valid));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // outcome vector {park,done,err,rx,wake}
  function automatic logic [4:0] outc();
    return {park_valid, done_valid, err_valid, rx_valid, wake_valid};
  endfunction

  task automatic send(logic [1:0] op, int ch, int pid, logic pri, logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_ch = CW'(ch);
    req_pid = PW'(pid); req_pri = pri; req_data = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_op = 2'b00;
  endtask

  task automatic pulse_irq_and_check(int pid, logic pri, string tag);
    @(negedge clk); irq = 1'b1;
    repeat (3) @(negedge clk);
    chk({tag, " wake"}, {wake_valid, wake_pid, wake_pri, wake_now}, {1'b1, PW'(pid), pri, pri});
    irq = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk("R1 ready", req_ready, 1);
    chk("R1 pulses", outc(), 5'b0);
    send(2'b10, 0, 5, 1'b0, 0);
    chk("R1 empty ch0 parks", {outc(), park_pid}, {5'b10000, PW'(5)});
  endtask

  task automatic t_in_first();
    send(2'b01, 0, 9, 1'b1, 32'hA5A5_0F0F);
    chk("R3 outcome", outc(), 5'b01011);
    chk("R3 rx", {rx_pid, rx_data}, {PW'(5), 32'hA5A5_0F0F});
    chk("R3 wake", {wake_pid, wake_pri, wake_now, done_pid}, {PW'(5), 1'b0, 1'b0, PW'(9)});
    send(2'b01, 0, 3, 1'b0, 32'hDEAD_0003);
    chk("R3 emptied ch0 parks", {outc(), park_pid}, {5'b10000, PW'(3)});
  endtask

  task automatic t_out_first();
    send(2'b01, 1, 7, 1'b1, 32'h1234_5678);
    chk("R2 sender parks", {outc(), park_pid}, {5'b10000, PW'(7)});
    send(2'b10, 1, 2, 1'b0, 0);
    chk("R3 in second", {outc(), rx_pid, rx_data}, {5'b01011, PW'(2), 32'h1234_5678});
    chk("R3 wake sender", {wake_pid, wake_pri, wake_now}, {PW'(7), 1'b1, 1'b0});
    send(2'b10, 0, 4, 1'b0, 0);
    chk("R6 ch0 kept parked data", {outc(), rx_pid, rx_data, wake_pid}, {5'b01011, PW'(4), 32'hDEAD_0003, PW'(3)});
  endtask

  task automatic t_same_dir();
    send(2'b01, 2, 1, 1'b0, 32'h11);
    send(2'b01, 2, 6, 1'b0, 32'h22);
    chk("R4 err only", outc(), 5'b00100);
    send(2'b10, 2, 8, 1'b0, 0);
    chk("R4 original kept", {outc(), rx_data, wake_pid}, {5'b01011, 32'h11, PW'(1)});
  endtask

  task automatic t_bad_ch();
    send(2'b01, 3, 6, 1'b0, 32'h33);
    chk("R5 err", outc(), 5'b00100);
    send(2'b10, 0, 6, 1'b0, 0);
    chk("R5 ch0 untouched parks", outc(), 5'b10000);
    send(2'b01, 0, 12, 1'b0, 32'h44);
    chk("R5 clean", {outc(), rx_data}, {5'b01011, 32'h44});
  endtask

  task automatic t_event_wait();
    send(2'b11, 0, 10, 1'b1, 0);
    chk("R7 parks on event", {outc(), park_pid}, {5'b10000, PW'(10)});
    pulse_irq_and_check(10, 1'b1, "R7 high");
    send(2'b11, 0, 20, 1'b0, 0);
    pulse_irq_and_check(20, 1'b0, "R7 low");
  endtask

  task automatic t_event_latched();
    int seen = 0;
    @(negedge clk); irq = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (wake_valid) seen++;
    end
    irq = 1'b0;
    chk("R8 no wake without waiter", seen, 0);
    send(2'b11, 0, 11, 1'b0, 0);
    chk("R8 latched done", {outc(), done_pid}, {5'b01000, PW'(11)});
    send(2'b11, 0, 12, 1'b0, 0);
    chk("R8 latch cleared, parks", outc(), 5'b10000);
    send(2'b11, 0, 13, 1'b0, 0);
    chk("R9 second waiter err", outc(), 5'b00100);
    pulse_irq_and_check(12, 1'b0, "R9 waiter kept");
  endtask

  task automatic t_stall();
    send(2'b11, 0, 14, 1'b1, 0);
    @(negedge clk); irq = 1'b1;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'b01; req_ch = 1; req_pid = 15; req_pri = 0; req_data = 32'h55;
    chk("R10 ready low", req_ready, 0);
    @(negedge clk);
    chk("R10 wake, not yet taken", {wake_valid, wake_pid, park_valid}, {1'b1, PW'(14), 1'b0});
    @(negedge clk);
    req_valid = 1'b0; req_op = 2'b00; irq = 1'b0;
    chk("R10 taken next edge", {park_valid, park_pid}, {1'b1, PW'(15)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_in_first();
    t_out_first();
    t_same_dir();
    t_bad_ch();
    t_event_wait();
    t_event_latched();
    t_stall();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule